// File: doc/BRIEF.md
# Bridge Parity and Error Reporting Unit

This unit sits beside the datapath of a bridge that joins a primary PCI-style bus to a secondary card-bus. On each side it watches address and data phases and computes even parity over the 32 AD bits and 4 C/BE bits. The parity bit for a phase arrives one clock after that phase. The unit compares it with its own result and produces the parity bit for the copy of the phase that goes out on the other side. Clean phases get freshly generated parity. A data phase that arrived with bad parity keeps its bad parity when it is forwarded, so the final target sees the original fault.

The unit also turns faults into reports. Address-parity faults, secondary system errors, and some abort cases raise a one-clock system-error pulse on the active-low `serr_n`. Data-parity faults raise a one-clock `perr_n` pulse. A master abort follows a chosen policy. It either returns all ones for a read and silently drops a write, or it escalates to a system error. A target abort is handed back to the originating master while that master is still connected, and escalates otherwise. Each cause is recorded in a sticky status vector that is cleared by writing ones.

Top module: `bbe_err_ctrl`

## Requirements
- R1: For a clean phase seen on one side in cycle t, the forwarded parity on the other side's output (`fwd_par_sec` for primary phases, `fwd_par_pri` for secondary ones) equals the XOR of the 32 AD bits and 4 C/BE bits during cycle t+1. That is even parity over 37 bits.
- R2: An address phase whose parity bit (sampled at t+1) disagrees with even parity drives `serr_n` low for exactly cycle t+2 when `serr_en` is 1. It also sets status bit 0 (any parity fault) and bit 1 (address parity).
- R3: A data phase with wrong parity drives `perr_n` low for exactly cycle t+2 when `perr_resp_en` is 1. It also sets status bits 0 and 2 (data parity).
- R4: For a data phase with wrong parity, the forwarded parity during t+1 equals the received bad parity bit and not the regenerated one. Address phases always forward regenerated parity.
- R5: When `serr_en` is 0, `serr_n` stays high. When `perr_resp_en` is 0, `perr_n` stays high. The status bits are set either way.
- R6: With `ma_mode`=0, a master abort at cycle t raises `rd_all_ones` (for a read) or `wr_discard` (for a write) for one cycle at t+1. It does not touch `serr_n`. Status bit 3 is set.
- R7: With `ma_mode`=1, a master abort drives `serr_n` low at t+1 and raises neither `rd_all_ones` nor `wr_discard`. Status bit 3 is set.
- R8: A target abort at t with `fwd_possible`=1 raises `ta_to_master` at t+1 and leaves `serr_n` high. With `fwd_possible`=0 it drives `serr_n` low at t+1 instead. Both cases set status bit 4.
- R9: A falling edge of `sec_serr_n` at cycle t drives `serr_n` low for the single cycle t+1, whatever the `ma_mode` setting. It also sets status bit 5.
- R10: Status bits are sticky. A 1 in `status_clr` clears the matching bit at the next edge. A new event in the same cycle wins over the clear.
- R11: After reset, `serr_n` and `perr_n` are 1, and the status vector and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serr_en | input | 1 | Enables system-error pulses |
| perr_resp_en | input | 1 | Enables data-parity pulses |
| ma_mode | input | 1 | Master-abort policy: 0 all-ones/discard, 1 system error |
| pri_addr_ph | input | 1 | Address phase on primary side |
| pri_data_ph | input | 1 | Data phase on primary side |
| pri_ad | input | 32 | Primary AD value |
| pri_cbe | input | 4 | Primary C/BE value |
| pri_par | input | 1 | Primary parity bit, one clock after the phase |
| sec_addr_ph | input | 1 | Address phase on secondary side |
| sec_data_ph | input | 1 | Data phase on secondary side |
| sec_ad | input | 32 | Secondary AD value |
| sec_cbe | input | 4 | Secondary C/BE value |
| sec_par | input | 1 | Secondary parity bit, one clock after the phase |
| ma_hit | input | 1 | Master abort at destination |
| ma_read | input | 1 | Aborted transaction is a read |
| ta_hit | input | 1 | Target abort at destination |
| fwd_possible | input | 1 | Originating master still connected |
| sec_serr_n | input | 1 | Secondary system-error input, active low |
| status_clr | input | 6 | Write-one-to-clear for status |
| serr_n | output | 1 | System error, active low, one clock per event |
| perr_n | output | 1 | Data parity error, active low, one clock per event |
| status | output | 6 | Sticky causes: 0 any parity, 1 addr parity, 2 data parity, 3 master abort, 4 target abort, 5 secondary system error |
| fwd_par_sec | output | 1 | Parity for primary phase forwarded to secondary |
| fwd_par_pri | output | 1 | Parity for secondary phase forwarded to primary |
| rd_all_ones | output | 1 | Replace read data with all ones |
| wr_discard | output | 1 | Drop the aborted write |
| ta_to_master | output | 1 | Signal target abort to originating master |

## Verification
Results fall on three different latencies, so each check samples only in the cycle its result is due. Forwarded parity is combinational on the parity bit received one clock after the phase, so it is read during that same cycle. Parity-fault pulses and their status bits come one register later, at the second edge after the phase. Abort, secondary-error and clear effects appear after the single edge that follows the stimulus. The bench samples one nanosecond after each falling edge. For the single-pulse requirements it also checks the following cycle to confirm that the pulse has ended.

// File: rtl/bbe_pkg.sv
package bbe_pkg;

    parameter int AD_W_DEF  = 32;
    parameter int CBE_W_DEF = 4;

    localparam int ST_W    = 6;
    localparam int ST_ANYP = 0;
    localparam int ST_ADRP = 1;
    localparam int ST_DATP = 2;
    localparam int ST_MABT = 3;
    localparam int ST_TABT = 4;
    localparam int ST_SSER = 5;

    typedef enum logic {
        MA_ALL_ONES = 1'b0,
        MA_SYSERR   = 1'b1
    } ma_mode_e;

    typedef struct packed {
        logic addr;
        logic data;
    } phase_t;

    typedef struct packed {
        logic addr_err;
        logic data_err;
    } pchk_t;

    function automatic logic [ST_W-1:0] cause_vec(
        input logic adr, input logic dat, input logic ma,
        input logic ta, input logic ss);
        logic [ST_W-1:0] v;
        v = '0;
        v[ST_ANYP] = adr | dat;
        v[ST_ADRP] = adr;
        v[ST_DATP] = dat;
        v[ST_MABT] = ma;
        v[ST_TABT] = ta;
        v[ST_SSER] = ss;
        return v;
    endfunction

endpackage

// File: rtl/bbe_parity_unit.sv
module bbe_parity_unit
    import bbe_pkg::*;
#(
    parameter int AD_W  = AD_W_DEF,
    parameter int CBE_W = CBE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_ph,
    input  logic             data_ph,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    input  logic             par_in,
    output pchk_t            chk,
    output logic             fwd_par
);

    phase_t ph_q;
    logic   gen_q;
    logic   mism;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            gen_q <= 1'b0;
        end else begin
            ph_q.addr <= addr_ph;
            ph_q.data <= data_ph;
            gen_q     <= ^{ad, cbe};
        end
    end

    always_comb begin
        mism         = par_in ^ gen_q;
        chk.addr_err = ph_q.addr & mism;
        chk.data_err = ph_q.data & mism;
        fwd_par      = chk.data_err ? par_in : gen_q;
    end

    AST_FWD_BAD: assert property (@(posedge clk) disable iff (rst)
        ($past(data_ph) && !$past(addr_ph) && (par_in != ^{$past(ad), $past(cbe)}))
            |-> (fwd_par == par_in)); // R4

endmodule

// File: rtl/bbe_err_policy.sv
module bbe_err_policy
    import bbe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            addr_err,
    input  logic            data_err,
    input  logic            ma_hit,
    input  logic            ma_read,
    input  ma_mode_e        ma_mode,
    input  logic            ta_hit,
    input  logic            fwd_possible,
    input  logic            sec_serr_n,
    input  logic            serr_en,
    input  logic            perr_en,
    output logic            serr_n,
    output logic            perr_n,
    output logic            rd_all_ones,
    output logic            wr_discard,
    output logic            ta_to_master,
    output logic [ST_W-1:0] set_vec
);

    logic sserr_q;
    logic sec_evt;
    logic ma_sys;
    logic ma_ones;
    logic ta_esc;
    logic serr_req;

    always_comb begin
        sec_evt  = sserr_q & ~sec_serr_n;
        ma_sys   = ma_hit & (ma_mode == MA_SYSERR);
        ma_ones  = ma_hit & (ma_mode == MA_ALL_ONES);
        ta_esc   = ta_hit & ~fwd_possible;
        serr_req = addr_err | ma_sys | ta_esc | sec_evt;
        set_vec  = cause_vec(addr_err, data_err, ma_hit, ta_hit, sec_evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sserr_q      <= 1'b1;
            serr_n       <= 1'b1;
            perr_n       <= 1'b1;
            rd_all_ones  <= 1'b0;
            wr_discard   <= 1'b0;
            ta_to_master <= 1'b0;
        end else begin
            sserr_q      <= sec_serr_n;
            serr_n       <= ~(serr_en & serr_req);
            perr_n       <= ~(perr_en & data_err);
            rd_all_ones  <= ma_ones & ma_read;
            wr_discard   <= ma_ones & ~ma_read;
            ta_to_master <= ta_hit & fwd_possible;
        end
    end

    AST_ADRP_SERR: assert property (@(posedge clk) disable iff (rst)
        (addr_err && serr_en) |=> !serr_n); // R2
    AST_DATP_PERR: assert property (@(posedge clk) disable iff (rst)
        (data_err && perr_en) |=> !perr_n); // R3
    AST_SERR_GATED: assert property (@(posedge clk) disable iff (rst)
        !serr_en |=> serr_n); // R5
    AST_PERR_GATED: assert property (@(posedge clk) disable iff (rst)
        !perr_en |=> perr_n); // R5
    AST_MA_ONES: assert property (@(posedge clk) disable iff (rst)
        (ma_hit && ma_mode == MA_ALL_ONES) |=> (rd_all_ones != wr_discard) && serr_n == !(serr_en && $past(serr_req))); // R6
    AST_MA_SYS: assert property (@(posedge clk) disable iff (rst)
        (ma_hit && ma_mode == MA_SYSERR && serr_en) |=> (!serr_n && !rd_all_ones && !wr_discard)); // R7
    AST_TA_BACK: assert property (@(posedge clk) disable iff (rst)
        (ta_hit && fwd_possible) |=> ta_to_master); // R8
    AST_SEC_SERR: assert property (@(posedge clk) disable iff (rst)
        ($fell(sec_serr_n) && serr_en) |=> !serr_n); // R9

endmodule

// File: rtl/bbe_status_reg.sv
module bbe_status_reg
    import bbe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_vec,
    input  logic [ST_W-1:0] clr_vec,
    output logic [ST_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_vec) | set_vec;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(q & ~clr_vec)) == $past(q & ~clr_vec))); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(set_vec)) == $past(set_vec))); // R10
    AST_W1C: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[ST_ANYP] && !set_vec[ST_ANYP]) |=> !q[ST_ANYP]); // R10

endmodule

// File: rtl/bbe_err_ctrl.sv
module bbe_err_ctrl
    import bbe_pkg::*;
#(
    parameter int AD_W  = AD_W_DEF,
    parameter int CBE_W = CBE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             serr_en,
    input  logic             perr_resp_en,
    input  logic             ma_mode,
    input  logic             pri_addr_ph,
    input  logic             pri_data_ph,
    input  logic [AD_W-1:0]  pri_ad,
    input  logic [CBE_W-1:0] pri_cbe,
    input  logic             pri_par,
    input  logic             sec_addr_ph,
    input  logic             sec_data_ph,
    input  logic [AD_W-1:0]  sec_ad,
    input  logic [CBE_W-1:0] sec_cbe,
    input  logic             sec_par,
    input  logic             ma_hit,
    input  logic             ma_read,
    input  logic             ta_hit,
    input  logic             fwd_possible,
    input  logic             sec_serr_n,
    input  logic [5:0]       status_clr,
    output logic             serr_n,
    output logic             perr_n,
    output logic [5:0]       status,
    output logic             fwd_par_sec,
    output logic             fwd_par_pri,
    output logic             rd_all_ones,
    output logic             wr_discard,
    output logic             ta_to_master
);

    localparam int NSIDE = 2;

    logic [NSIDE-1:0]            s_addr_ph;
    logic [NSIDE-1:0]            s_data_ph;
    logic [NSIDE-1:0][AD_W-1:0]  s_ad;
    logic [NSIDE-1:0][CBE_W-1:0] s_cbe;
    logic [NSIDE-1:0]            s_par;
    logic [NSIDE-1:0]            s_fwd;
    pchk_t [NSIDE-1:0]           s_chk;
    logic [NSIDE-1:0]            s_aerr;
    logic [NSIDE-1:0]            s_derr;
    logic [ST_W-1:0]             set_vec;

    assign s_addr_ph = {sec_addr_ph, pri_addr_ph};
    assign s_data_ph = {sec_data_ph, pri_data_ph};
    assign s_ad      = {sec_ad, pri_ad};
    assign s_cbe     = {sec_cbe, pri_cbe};
    assign s_par     = {sec_par, pri_par};

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        bbe_parity_unit #(.AD_W(AD_W), .CBE_W(CBE_W)) u_par (
            .clk     (clk),
            .rst     (rst),
            .addr_ph (s_addr_ph[g]),
            .data_ph (s_data_ph[g]),
            .ad      (s_ad[g]),
            .cbe     (s_cbe[g]),
            .par_in  (s_par[g]),
            .chk     (s_chk[g]),
            .fwd_par (s_fwd[g])
        );
        assign s_aerr[g] = s_chk[g].addr_err;
        assign s_derr[g] = s_chk[g].data_err;
    end

    assign fwd_par_sec = s_fwd[0];
    assign fwd_par_pri = s_fwd[1];

    bbe_err_policy u_pol (
        .clk          (clk),
        .rst          (rst),
        .addr_err     (|s_aerr),
        .data_err     (|s_derr),
        .ma_hit       (ma_hit),
        .ma_read      (ma_read),
        .ma_mode      (ma_mode_e'(ma_mode)),
        .ta_hit       (ta_hit),
        .fwd_possible (fwd_possible),
        .sec_serr_n   (sec_serr_n),
        .serr_en      (serr_en),
        .perr_en      (perr_resp_en),
        .serr_n       (serr_n),
        .perr_n       (perr_n),
        .rd_all_ones  (rd_all_ones),
        .wr_discard   (wr_discard),
        .ta_to_master (ta_to_master),
        .set_vec      (set_vec)
    );

    bbe_status_reg u_st (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (status_clr),
        .q       (status)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (serr_n && perr_n && status == '0 && !rd_all_ones && !wr_discard && !ta_to_master)); // R11

endmodule

// File: tb/bbe_err_ctrl_tb.sv
`timescale 1ns/1ps
module bbe_err_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic serr_en = 1'b1, perr_resp_en = 1'b1, ma_mode = 1'b0;
    logic pri_addr_ph = 0, pri_data_ph = 0, pri_par = 0;
    logic sec_addr_ph = 0, sec_data_ph = 0, sec_par = 0;
    logic [31:0] pri_ad = '0, sec_ad = '0;
    logic [3:0]  pri_cbe = '0, sec_cbe = '0;
    logic ma_hit = 0, ma_read = 0, ta_hit = 0, fwd_possible = 0;
    logic sec_serr_n = 1'b1;
    logic [5:0] status_clr = '0;
    logic serr_n, perr_n, fwd_par_sec, fwd_par_pri;
    logic rd_all_ones, wr_discard, ta_to_master;
    logic [5:0] status;

    int checks = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    bbe_err_ctrl u_dut (
        .clk(clk), .rst(rst), .serr_en(serr_en), .perr_resp_en(perr_resp_en),
        .ma_mode(ma_mode), .pri_addr_ph(pri_addr_ph), .pri_data_ph(pri_data_ph),
        .pri_ad(pri_ad), .pri_cbe(pri_cbe), .pri_par(pri_par),
        .sec_addr_ph(sec_addr_ph), .sec_data_ph(sec_data_ph), .sec_ad(sec_ad),
        .sec_cbe(sec_cbe), .sec_par(sec_par), .ma_hit(ma_hit), .ma_read(ma_read),
        .ta_hit(ta_hit), .fwd_possible(fwd_possible), .sec_serr_n(sec_serr_n),
        .status_clr(status_clr), .serr_n(serr_n), .perr_n(perr_n), .status(status),
        .fwd_par_sec(fwd_par_sec), .fwd_par_pri(fwd_par_pri),
        .rd_all_ones(rd_all_ones), .wr_discard(wr_discard), .ta_to_master(ta_to_master)
    );

    // {side(1=secondary), is_addr, bad_parity, ad, cbe}
    localparam logic [38:0] VEC [8] = '{
        {1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 4'hA},
        {1'b0, 1'b0, 1'b0, 32'h00000000, 4'h0},
        {1'b0, 1'b0, 1'b1, 32'h12345678, 4'hF},
        {1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 4'h5},
        {1'b1, 1'b1, 1'b0, 32'h0F0F0F0F, 4'h3},
        {1'b1, 1'b0, 1'b1, 32'h80000001, 4'h8},
        {1'b1, 1'b1, 1'b1, 32'hCAFEF00D, 4'h1},
        {1'b1, 1'b0, 1'b0, 32'h7FFFFFFF, 4'hE}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_status();
        @(negedge clk) status_clr = '1;
        @(negedge clk) status_clr = '0;
    endtask

    task automatic run_par(input logic side, input logic is_addr, input logic bad,
                           input logic [31:0] ad, input logic [3:0] cbe);
        logic gen, rx, exp_fwd;
        logic [5:0] exp_st;
        gen = ^{ad, cbe};
        rx  = gen ^ bad;
        exp_fwd = (bad && !is_addr) ? rx : gen;
        exp_st = '0;
        if (bad) exp_st = is_addr ? 6'b000011 : 6'b000101;
        @(negedge clk);
        if (side) begin
            sec_addr_ph = is_addr; sec_data_ph = !is_addr; sec_ad = ad; sec_cbe = cbe;
        end else begin
            pri_addr_ph = is_addr; pri_data_ph = !is_addr; pri_ad = ad; pri_cbe = cbe;
        end
        @(negedge clk);
        pri_addr_ph = 0; pri_data_ph = 0; sec_addr_ph = 0; sec_data_ph = 0;
        if (side) sec_par = rx; else pri_par = rx;
        #1;
        if (side) chk(bad ? "R4 fwd_par_pri" : "R1 fwd_par_pri", {31'd0, fwd_par_pri}, {31'd0, exp_fwd});
        else      chk(bad ? "R4 fwd_par_sec" : "R1 fwd_par_sec", {31'd0, fwd_par_sec}, {31'd0, exp_fwd});
        @(negedge clk);
        pri_par = 0; sec_par = 0;
        #1;
        chk("R2 serr_n", {31'd0, serr_n}, {31'd0, !(bad && is_addr && serr_en)});
        chk("R3 perr_n", {31'd0, perr_n}, {31'd0, !(bad && !is_addr && perr_resp_en)});
        chk("R2 R3 status", {26'd0, status}, {26'd0, exp_st});
        @(negedge clk); #1;
        chk("R2 R3 single pulse", {30'd0, serr_n, perr_n}, 32'd3);
        clear_status();
    endtask

    task automatic abort_pulse(input logic ma, input logic rd, input logic ta, input logic fw);
        @(negedge clk);
        ma_hit = ma; ma_read = rd; ta_hit = ta; fwd_possible = fw;
        @(negedge clk);
        ma_hit = 0; ta_hit = 0;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL R11 watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset serr/perr", {30'd0, serr_n, perr_n}, 32'd3);
        chk("R11 reset status", {26'd0, status}, 32'd0);
        chk("R11 reset pulses", {29'd0, rd_all_ones, wr_discard, ta_to_master}, 32'd0);

        for (int i = 0; i < 8; i++)
            run_par(VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:4], VEC[i][3:0]);

        // R5: enables off, status still recorded
        serr_en = 0; perr_resp_en = 0;
        run_par(1'b0, 1'b1, 1'b1, 32'hA5A5A5A5, 4'h6);
        run_par(1'b1, 1'b0, 1'b1, 32'h00FF00FF, 4'h9);
        serr_en = 1; perr_resp_en = 1;

        // R6 master abort, all-ones policy
        ma_mode = 0;
        abort_pulse(1, 1, 0, 0);
        chk("R6 read all ones", {29'd0, rd_all_ones, wr_discard, serr_n}, 32'b101);
        chk("R6 status", {26'd0, status}, 32'b001000);
        @(negedge clk); #1;
        chk("R6 pulse ends", {31'd0, rd_all_ones}, 32'd0);
        abort_pulse(1, 0, 0, 0);
        chk("R6 write discard", {29'd0, rd_all_ones, wr_discard, serr_n}, 32'b011);
        clear_status();

        // R7 master abort, system-error policy
        ma_mode = 1;
        abort_pulse(1, 1, 0, 0);
        chk("R7 serr on master abort", {29'd0, rd_all_ones, wr_discard, serr_n}, 32'b000);
        chk("R7 status", {26'd0, status}, 32'b001000);
        clear_status();

        // R8 target abort
        abort_pulse(0, 0, 1, 1);
        chk("R8 ta back to master", {30'd0, ta_to_master, serr_n}, 32'b11);
        chk("R8 status", {26'd0, status}, 32'b010000);
        abort_pulse(0, 0, 1, 0);
        chk("R8 ta escalated", {30'd0, ta_to_master, serr_n}, 32'b00);
        clear_status();

        // R9 secondary system error, both modes
        for (int m = 0; m < 2; m++) begin
            ma_mode = m[0];
            @(negedge clk) sec_serr_n = 0;
            @(negedge clk); #1;
            chk("R9 secondary serr", {31'd0, serr_n}, 32'd0);
            chk("R9 status", {26'd0, status}, 32'b100000);
            @(negedge clk); #1;
            chk("R9 single pulse while held", {31'd0, serr_n}, 32'd1);
            sec_serr_n = 1;
            clear_status();
        end

        // R10 sticky, selective W1C, set beats clear
        ma_mode = 0;
        abort_pulse(1, 1, 0, 0);
        abort_pulse(0, 0, 1, 1);
        chk("R10 sticky", {26'd0, status}, 32'b011000);
        @(negedge clk) status_clr = 6'b001000;
        @(negedge clk) status_clr = '0;
        #1;
        chk("R10 selective clear", {26'd0, status}, 32'b010000);
        @(negedge clk) begin ma_hit = 1; ma_read = 1; status_clr = 6'b001000; end
        @(negedge clk) begin ma_hit = 0; status_clr = '0; end
        #1;
        chk("R10 set wins over clear", {26'd0, status}, 32'b011000);
        clear_status();
        #1;
        chk("R10 cleared", {26'd0, status}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule